// File: doc/BRIEF.md
# Atomic Compare-and-Swap Line Unit

This block holds one data line as a small internal byte array and performs single atomic read-modify-write operations on it. A requester presents a byte offset, an access size in bytes, an operand, a compare value and a select bit. The select bit chooses between an unconditional swap and a conditional swap. The unit returns the bytes that were stored at the addressed location before the operation. It also reports whether a write took place and whether the request was rejected as an error.

An unconditional swap always stores the operand over the addressed bytes. A conditional swap stores the operand only when the current contents match the compare value. The match uses all 64 bits for an 8-byte access and only the low 32 bits for a 4-byte access. A conditional swap of any other size is refused. Requests are accepted one at a time. The unit shows it is occupied during the cycle after acceptance, and a one-cycle response follows that cycle.

Top module: `cas_line_unit`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0 and every byte of the line reads as zero.
- R2: A request is taken at a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 for exactly the next cycle. `rsp_valid` is 1 for exactly the cycle after that, and `busy` is 0 in that cycle.
- R3: A request presented while `busy` is 1 is not taken. It produces no response and changes no stored byte.
- R4: `rsp_old` carries the stored bytes from `offset` to `offset+size-1` as they were before the operation. Byte `offset` is in bits [7:0], the next byte is in bits [15:8], and so on. Bits above `8*size` are zero. This holds whether or not a write happens.
- R5: An unconditional swap (`req_cond`=0) of 1 to 8 bytes writes the low `size` bytes of `req_operand` into the addressed bytes and reports `rsp_wrote`=1.
- R6: A conditional swap (`req_cond`=1) of 8 bytes writes the operand only when all 64 stored bits equal `req_compare`. `rsp_wrote` reports whether the write happened.
- R7: A conditional swap of 4 bytes compares only the stored 32 bits against `req_compare[31:0]`. Bits [63:32] of `req_compare` have no effect.
- R8: A conditional swap with a size other than 4 or 8 sets `rsp_err` and writes nothing.
- R9: A size of 0, a size above 8, or `offset+size` beyond the line length sets `rsp_err` and writes nothing, for either kind of swap.
- R10: An error response has `rsp_wrote`=0 and `rsp_old`=0.
- R11: Bytes outside the addressed range are never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_cond | input | 1 | 1 = conditional swap, 0 = unconditional swap |
| req_offset | input | log2(LINE_BYTES) | Byte offset of the access within the line |
| req_size | input | 4 | Access size in bytes |
| req_operand | input | 64 | New data, low bytes used |
| req_compare | input | 64 | Expected contents for a conditional swap |
| busy | output | 1 | Unit occupied; requests are not taken |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_old | output | 64 | Previous contents of the addressed bytes |
| rsp_err | output | 1 | Request refused |
| rsp_wrote | output | 1 | Operand was stored |

## Verification
A wrong byte in the line does not show up when it is corrupted. It shows up at the next access that covers it, as a wrong `rsp_old` value, or as a conditional swap whose `rsp_wrote` does not match. For this reason the bench ends each scenario by reading the whole line back through failing conditional swaps. A wrong handshake state shows within one cycle as a mismatch on `busy` or `rsp_valid`. The per-clock model catches that mismatch on the edge where it first occurs.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int unsigned MAX_BYTES = 8;
  localparam int unsigned WORD_W    = MAX_BYTES * 8;
  localparam int unsigned SIZE_W    = 4;
  localparam int unsigned HALF_BYTES = MAX_BYTES / 2;

  typedef struct packed {
    logic              cond;
    logic [SIZE_W-1:0] size;
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] compare;
  } cas_op_t;
endpackage

// File: rtl/cas_req_stage.sv
module cas_req_stage
  import cas_pkg::*;
#(
  parameter int unsigned OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  cas_op_t          req_op,
  input  logic [OFF_W-1:0] req_offset,
  output logic             busy,
  output cas_op_t          cap_op,
  output logic [OFF_W-1:0] cap_offset
);
  logic fire;
  assign fire = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cap_op     <= '0;
      cap_offset <= '0;
    end else begin
      busy <= fire;
      if (fire) begin
        cap_op     <= req_op;
        cap_offset <= req_offset;
      end
    end
  end

  // R3: the captured request is held while the unit is occupied
  p_hold_capture_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cap_op) && $stable(cap_offset)));
endmodule

// File: rtl/cas_line_store.sv
module cas_line_store
  import cas_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word
);
  logic [7:0]            mem     [LINE_BYTES];
  logic [LINE_BYTES-1:0] byte_we;
  logic [7:0]            byte_wd [LINE_BYTES];

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      byte_we[b] = wr_en && (b >= int'(acc_off)) &&
                   (b < int'(acc_off) + int'(wr_size));
      byte_wd[b] = wr_data[8*((b - int'(acc_off)) & (MAX_BYTES-1)) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < LINE_BYTES; b++) mem[b] <= '0;
    end else begin
      for (int b = 0; b < LINE_BYTES; b++)
        if (byte_we[b]) mem[b] <= byte_wd[b];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (int'(acc_off) + k < LINE_BYTES)
        rd_word[8*k +: 8] = mem[int'(acc_off) + k];
  end

  // R11: never more lanes than one access may cover
  p_wen_bound_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(byte_we) <= MAX_BYTES);
  // R11: no lane is enabled without a write request
  p_wen_gated_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (byte_we == '0));
endmodule

// File: rtl/cas_decide.sv
module cas_decide
  import cas_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
  input  cas_op_t           op,
  input  logic [OFF_W-1:0]  offset,
  input  logic [WORD_W-1:0] stored,
  output logic              err,
  output logic              do_write,
  output logic [WORD_W-1:0] old_out
);
  localparam int unsigned SUM_W = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 1;

  logic [SUM_W-1:0]  end_pos;
  logic              range_ok, cond_size_ok, match;
  logic [WORD_W-1:0] lane_mask;

  assign end_pos      = SUM_W'(offset) + SUM_W'(op.size);
  assign range_ok     = (op.size != '0) && (op.size <= SIZE_W'(MAX_BYTES)) &&
                        (end_pos <= SUM_W'(LINE_BYTES));
  assign cond_size_ok = (op.size == SIZE_W'(MAX_BYTES)) ||
                        (op.size == SIZE_W'(HALF_BYTES));
  assign err          = !range_ok || (op.cond && !cond_size_ok);

  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++)
      lane_mask[8*k +: 8] = (k < int'(op.size)) ? 8'hFF : 8'h00;
  end

  assign match = (op.size == SIZE_W'(MAX_BYTES)) ?
                 (stored == op.compare) :
                 (stored[8*HALF_BYTES-1:0] == op.compare[8*HALF_BYTES-1:0]);

  assign do_write = !err && (!op.cond || match);
  assign old_out  = err ? '0 : (stored & lane_mask);
endmodule

// File: rtl/cas_line_unit.sv
module cas_line_unit
  import cas_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_cond,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [WORD_W-1:0] req_operand,
  input  logic [WORD_W-1:0] req_compare,
  output logic              busy,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_old,
  output logic              rsp_err,
  output logic              rsp_wrote
);
  cas_op_t           in_op, cap_op;
  logic [OFF_W-1:0]  cap_offset;
  logic [WORD_W-1:0] stored;
  logic              err, do_write;
  logic [WORD_W-1:0] old_val;

  assign in_op = '{cond: req_cond, size: req_size,
                   operand: req_operand, compare: req_compare};

  cas_req_stage #(.OFF_W(OFF_W)) u_stage (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(in_op),
    .req_offset(req_offset), .busy(busy), .cap_op(cap_op),
    .cap_offset(cap_offset)
  );

  cas_line_store #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_store (
    .clk(clk), .rst(rst), .acc_off(cap_offset),
    .wr_en(busy && do_write), .wr_size(cap_op.size),
    .wr_data(cap_op.operand), .rd_word(stored)
  );

  cas_decide #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_decide (
    .op(cap_op), .offset(cap_offset), .stored(stored),
    .err(err), .do_write(do_write), .old_out(old_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_old   <= '0;
      rsp_err   <= 1'b0;
      rsp_wrote <= 1'b0;
    end else begin
      rsp_valid <= busy;
      if (busy) begin
        rsp_old   <= old_val;
        rsp_err   <= err;
        rsp_wrote <= do_write;
      end
    end
  end

  // R2: occupancy lasts one cycle and is followed by the response
  p_busy_then_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> (rsp_valid && !busy));
  // R2: response cycle never overlaps occupancy
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);
  // R8: unsupported conditional size is refused
  p_cond_size_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cap_op.cond && (cap_op.size != 4'd4) && (cap_op.size != 4'd8))
      |=> rsp_err);
  // R10: an error response carries neither data nor a write
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (!rsp_wrote && (rsp_old == '0)));
endmodule

// File: tb/cas_line_unit_bench.sv
module cas_line_unit_bench;
  localparam int LB = 16;

  logic        clk = 0;
  logic        rst;
  logic        req_valid, req_cond;
  logic [3:0]  req_offset;
  logic [3:0]  req_size;
  logic [63:0] req_operand, req_compare;
  logic        busy, rsp_valid, rsp_err, rsp_wrote;
  logic [63:0] rsp_old;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] ref_mem [LB];
  logic m_busy, m_rsp;

  always #10 clk = ~clk;

  cas_line_unit #(.LINE_BYTES(LB)) u_cas_line_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cond(req_cond),
    .req_offset(req_offset), .req_size(req_size), .req_operand(req_operand),
    .req_compare(req_compare), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_old(rsp_old), .rsp_err(rsp_err), .rsp_wrote(rsp_wrote)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 handshake model, compared every clock
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0;
      m_rsp  <= 0;
    end else begin
      m_busy <= req_valid && !m_busy;
      m_rsp  <= m_busy;
    end
  end
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 busy", {63'd0, busy}, {63'd0, m_busy});
      chk("R2 rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rsp});
    end
  end

  function automatic logic [63:0] ref_read(int off, int sz);
    logic [63:0] v = '0;
    for (int k = 0; k < sz; k++)
      if (off + k < LB) v[8*k +: 8] = ref_mem[off + k];
    return v;
  endfunction

  task automatic op(string tag, bit cond, int off, int sz,
                    logic [63:0] opnd, logic [63:0] cmp, bit hold);
    bit e, w, m;
    logic [63:0] old;
    e = (sz == 0) || (sz > 8) || (off + sz > LB) || (cond && sz != 4 && sz != 8);
    old = e ? 64'd0 : ref_read(off, sz);
    m = (sz == 8) ? (old == cmp) : (old[31:0] == cmp[31:0]);
    w = !e && (!cond || m);
    @(negedge clk);
    req_valid = 1; req_cond = cond; req_offset = 4'(off);
    req_size = 4'(sz); req_operand = opnd; req_compare = cmp;
    @(negedge clk);
    if (hold) begin
      req_cond = 0; req_offset = 0; req_size = 4'd8;
      req_operand = 64'hDEAD_BEEF_DEAD_BEEF;   // R3 must be ignored
    end else req_valid = 0;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R4 old"}, rsp_old, old);
    chk({tag, " err"}, {63'd0, rsp_err}, {63'd0, e});
    chk({tag, " wrote"}, {63'd0, rsp_wrote}, {63'd0, w});
    if (w) for (int k = 0; k < sz; k++) ref_mem[off + k] = opnd[8*k +: 8];
  endtask

  // R11/R1: read the whole line back through failing conditional swaps
  task automatic dump(string tag);
    for (int o = 0; o < LB; o += 8) op(tag, 1, o, 8, 64'h0, ~ref_read(o, 8), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LB; i++) ref_mem[i] = 8'h00;
    rst = 1; req_valid = 0; req_cond = 0; req_offset = 0; req_size = 0;
    req_operand = 0; req_compare = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    rst = 0;
    dump("R1 zero line");
    op("R5 swap8", 0, 0, 8, 64'h0123_4567_89AB_CDEF, 0, 0);
    op("R6 cas8 hit", 1, 0, 8, 64'hA5A5_0000_FFFF_1111, 64'h0123_4567_89AB_CDEF, 0);
    op("R6 cas8 miss", 1, 0, 8, 64'h1, 64'h0123_4567_89AB_CDEF, 0);
    op("R4 swap2 off3", 0, 3, 2, 64'hFFFF_FFFF_FFFF_1234, 0, 0);
    op("R5 swap1 off15", 0, 15, 1, 64'h77, 0, 0);
    op("R5 swap4 off8", 0, 8, 4, 64'h1122_3344, 0, 0);
    op("R7 cas4 upper ignored", 1, 8, 4, 64'h5566_7788, 64'hFFFF_0000_1122_3344, 0);
    op("R7 cas4 miss", 1, 8, 4, 64'h9999, 64'h0000_0000_1122_3345, 0);
    op("R8 cas size2", 1, 2, 2, 64'hBBBB, 64'h0, 0);
    op("R8 cas size1", 1, 0, 1, 64'hCC, {56'd0, ref_mem[0]}, 0);
    op("R9 size0", 0, 0, 0, 64'h55, 0, 0);
    op("R9 size9", 0, 0, 9, 64'h55, 0, 0);
    op("R9 R10 past end", 0, 12, 8, 64'h55, 0, 0);
    op("R9 cas past end", 1, 12, 8, 64'h55, 64'h0, 0);
    op("R3 held during busy", 0, 4, 4, 64'hCAFE_F00D, 0, 1);
    dump("R11 line intact");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule